// File: doc/BRIEF.md
# Configuration Access Router

This block takes single configuration-space requests (read or write, one, two or four bytes) addressed by bus, device, function and register offset. It decides whether the request is legal and where it goes. Requests aimed at the root bus are served from the local root-port configuration space, through a word-wide port that accepts only whole-word writes. Requests for any other bus go out on a second word-wide port as a flat memory-mapped window address. Every request ends with exactly one response that carries a two-bit status and, for reads, the requested bytes shifted down to bit 0.

The block handles one request at a time. A state machine steps through the states IDLE, CHECK, LOC_READ, LOC_WRITE, REMOTE and RESPOND. The transitions are as follows:
- IDLE to CHECK when a request is accepted.
- CHECK to RESPOND when the status is not success.
- CHECK to REMOTE for a legal request to a non-root bus.
- CHECK to LOC_WRITE for a legal whole-word local write.
- CHECK to LOC_READ for a local read or a local narrow write.
- LOC_READ to LOC_WRITE on acknowledge when the request is a write.
- LOC_READ to RESPOND on acknowledge when the request is a read.
- LOC_WRITE to RESPOND on acknowledge.
- REMOTE to RESPOND on acknowledge.
- RESPOND to IDLE when the response is taken.

Top module: `cfg_access_router`

## Requirements
- R1: A remote access uses the 28-bit byte address {bus[7:0], device[4:0], function[2:0], register[11:0]}. Bus occupies bits 27:20, device bits 19:15, function bits 14:12 and register bits 11:0.
- R2: A request with a legal size whose register offset is not a multiple of that size returns status 1 (bad register). It makes no local or remote access, and its read data is zero.
- R3: A size other than 1, 2 or 4 returns status 1 (bad register) and makes no access.
- R4: A device number other than 0 on the root bus returns status 2 (device not found). The same applies on any bus whose primary bus is the root bus. Such a request makes no access and its read data is all ones. This check takes priority over R2 and R3.
- R5: A legal request on the root bus goes only to the local port, at word address register[11:2] (loc_addr = register with the low two bits cleared). A legal request on any other bus goes only to the remote port.
- R6: A local write of 1 or 2 bytes reads the word first, then writes it back. Bytes outside the target lanes keep their old value. The target lanes take the write data, shifted left by 8×(register mod 4). Write data bits above the request size are ignored.
- R7: A local 4-byte write is a single whole-word write, with no read before it.
- R8: A remote write is a single access with no read. Its byte enables are ((1<<size)−1)<<(register mod 4), where bit i covers data bits 8i+7:8i. Its data is the write data shifted to those lanes, with every other lane zero.
- R9: Read data from either port is the addressed word shifted right by 8×(register mod 4) and zero-extended above the request size.
- R10: The response status is 0 for success, 1 for bad register and 2 for device not found.
- R11: req_ready is high only while idle. A port request is held, with a stable address, until it is acknowledged. A response is held, with stable status and data, until rsp_ready.
- R12: During and right after reset, req_ready is high and rsp_valid, loc_req and rem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_bus | input | 8 | Bus number of the root port |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_primary | input | 8 | Primary (upstream) bus of the target bus |
| req_dev | input | 5 | Target device |
| req_func | input | 3 | Target function |
| req_reg | input | 12 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_status | output | 2 | Completion status |
| rsp_rdata | output | 32 | Read data, right-aligned |
| loc_req | output | 1 | Local port access request |
| loc_we | output | 1 | Local port write |
| loc_addr | output | 12 | Local word address (byte offset, low bits zero) |
| loc_wdata | output | 32 | Local write word |
| loc_ack | input | 1 | Local access done |
| loc_rdata | input | 32 | Local read word |
| rem_req | output | 1 | Remote port access request |
| rem_we | output | 1 | Remote port write |
| rem_addr | output | 28 | Remote byte address |
| rem_be | output | 4 | Remote byte enables |
| rem_wdata | output | 32 | Remote write data in lane position |
| rem_ack | input | 1 | Remote access done |
| rem_rdata | input | 32 | Remote read word |

## Verification
Some properties are checked by assertions on every cycle:
- Port requests and responses are held steady until their handshakes complete.
- No port is touched while the latched status is an error.
- Local accesses go only to the root bus and remote accesses only to other buses.
- A narrow local write always follows an acknowledged read, while a whole-word write never does.
- Remote write strobes match the size.

The bench scenarios must show the rest against its own reference computation:
- the actual byte values: merged words, lane-placed remote data and extracted read data;
- the window address layout;
- the priority of device-not-found over alignment errors;
- the all-ones read data and the reset state.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int REG_W  = 12;
    localparam int SIZE_W = 3;
    localparam int DATA_W = 32;
    localparam int BYTES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(BYTES);
    localparam int ECAM_W = BUS_W + DEV_W + FN_W + REG_W;

    typedef enum logic [1:0] {
        CFG_OK      = 2'd0,
        CFG_BAD_REG = 2'd1,
        CFG_NO_DEV  = 2'd2
    } cfg_status_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_LOC_READ,
        ST_LOC_WRITE,
        ST_REMOTE,
        ST_RESPOND
    } route_state_e;

    typedef struct packed {
        logic              write;
        logic [BUS_W-1:0]  bus;
        logic [BUS_W-1:0]  primary;
        logic [DEV_W-1:0]  dev;
        logic [FN_W-1:0]   func;
        logic [REG_W-1:0]  regno;
        logic [SIZE_W-1:0] size;
        logic [DATA_W-1:0] wdata;
    } cfg_req_t;
endpackage

// File: rtl/cfg_req_check.sv
module cfg_req_check
    import cfg_route_pkg::*;
(
    input  cfg_req_t           req,
    input  logic [BUS_W-1:0]   root_bus,
    output cfg_status_e        status,
    output logic               go_local,
    output logic               full_word,
    output logic [OFF_W-1:0]   lane_off,
    output logic [BYTES-1:0]   lane_be,
    output logic [ECAM_W-1:0]  ecam_addr
);
    logic             size_ok;
    logic             aligned;
    logic             near_root;
    logic [BYTES-1:0] width_be;

    always_comb begin
        size_ok   = (req.size != '0)
                 && ((req.size & (req.size - SIZE_W'(1))) == '0)
                 && (req.size <= SIZE_W'(BYTES));
        aligned   = (req.regno[OFF_W-1:0] & OFF_W'(req.size - SIZE_W'(1))) == '0;
        near_root = (req.bus == root_bus) || (req.primary == root_bus);

        // Device legality wins over size and alignment (R4)
        if (near_root && (req.dev != '0))
            status = CFG_NO_DEV;
        else if (!size_ok || !aligned)
            status = CFG_BAD_REG;
        else
            status = CFG_OK;

        for (int i = 0; i < BYTES; i++)
            width_be[i] = size_ok && (SIZE_W'(i) < req.size);

        lane_off  = req.regno[OFF_W-1:0];
        lane_be   = width_be << lane_off;
        full_word = (req.size == SIZE_W'(BYTES));
        go_local  = (req.bus == root_bus);
        ecam_addr = {req.bus, req.dev, req.func, req.regno};
    end
endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
    import cfg_route_pkg::*;
(
    input  logic [BYTES-1:0]  lane_be,
    input  logic [OFF_W-1:0]  lane_off,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] lane_wdata,
    output logic [DATA_W-1:0] merged,
    output logic [DATA_W-1:0] rd_field
);
    localparam int SH_W = OFF_W + 3;

    logic [BYTES-1:0]  width_be;
    logic [DATA_W-1:0] bit_mask;
    logic [DATA_W-1:0] width_mask;
    logic [SH_W-1:0]   shift_bits;

    assign width_be   = lane_be >> lane_off;
    assign shift_bits = {lane_off, 3'b000};

    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        assign bit_mask[8*g +: 8]   = {8{lane_be[g]}};
        assign width_mask[8*g +: 8] = {8{width_be[g]}};
    end

    always_comb begin
        lane_wdata = (wdata << shift_bits) & bit_mask;
        merged     = (word & ~bit_mask) | lane_wdata;
        rd_field   = (word >> shift_bits) & width_mask;
    end
endmodule

// File: rtl/cfg_route_fsm.sv
module cfg_route_fsm
    import cfg_route_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  cfg_status_e  chk_status,
    input  logic         chk_local,
    input  logic         chk_full,
    input  logic         is_write,
    input  logic         loc_ack,
    input  logic         rem_ack,
    input  logic         rsp_ready,
    output route_state_e state,
    output logic         req_ready,
    output logic         loc_req,
    output logic         loc_we,
    output logic         rem_req,
    output logic         rsp_valid
);
    route_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (req_valid) nxt = ST_CHECK;
            ST_CHECK: begin
                if (chk_status != CFG_OK)      nxt = ST_RESPOND;
                else if (!chk_local)           nxt = ST_REMOTE;
                else if (is_write && chk_full) nxt = ST_LOC_WRITE;
                else                           nxt = ST_LOC_READ;
            end
            ST_LOC_READ:  if (loc_ack) nxt = is_write ? ST_LOC_WRITE : ST_RESPOND;
            ST_LOC_WRITE: if (loc_ack) nxt = ST_RESPOND;
            ST_REMOTE:    if (rem_ack) nxt = ST_RESPOND;
            ST_RESPOND:   if (rsp_ready) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        loc_req   = 1'b0;
        loc_we    = 1'b0;
        rem_req   = 1'b0;
        rsp_valid = 1'b0;
        unique case (state)
            ST_IDLE:      req_ready = 1'b1;
            ST_CHECK:     ;
            ST_LOC_READ:  loc_req = 1'b1;
            ST_LOC_WRITE: begin loc_req = 1'b1; loc_we = 1'b1; end
            ST_REMOTE:    rem_req = 1'b1;
            ST_RESPOND:   rsp_valid = 1'b1;
            default:      ;
        endcase
    end

    assert_rsp_until_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid);
    assert_idle_after_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready |=> req_ready);
    assert_loc_until_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        loc_req && !loc_ack |=> loc_req && $stable(loc_we));
    assert_rem_until_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rem_req && !rem_ack |=> rem_req);
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
    import cfg_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  root_bus,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [BUS_W-1:0]  req_primary,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_func,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              loc_req,
    output logic              loc_we,
    output logic [REG_W-1:0]  loc_addr,
    output logic [DATA_W-1:0] loc_wdata,
    input  logic              loc_ack,
    input  logic [DATA_W-1:0] loc_rdata,
    output logic              rem_req,
    output logic              rem_we,
    output logic [ECAM_W-1:0] rem_addr,
    output logic [BYTES-1:0]  rem_be,
    output logic [DATA_W-1:0] rem_wdata,
    input  logic              rem_ack,
    input  logic [DATA_W-1:0] rem_rdata
);
    cfg_req_t          req_q;
    cfg_status_e       status_q;
    logic [DATA_W-1:0] word_q;
    route_state_e      state;

    cfg_status_e       chk_status;
    logic              chk_local;
    logic              chk_full;
    logic [OFF_W-1:0]  lane_off;
    logic [BYTES-1:0]  lane_be;
    logic [ECAM_W-1:0] ecam_addr;
    logic [DATA_W-1:0] lane_wdata;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] rd_field;

    cfg_req_check u_check (
        .req       (req_q),
        .root_bus  (root_bus),
        .status    (chk_status),
        .go_local  (chk_local),
        .full_word (chk_full),
        .lane_off  (lane_off),
        .lane_be   (lane_be),
        .ecam_addr (ecam_addr)
    );

    cfg_lane_unit u_lanes (
        .lane_be    (lane_be),
        .lane_off   (lane_off),
        .wdata      (req_q.wdata),
        .word       (word_q),
        .lane_wdata (lane_wdata),
        .merged     (merged),
        .rd_field   (rd_field)
    );

    cfg_route_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .chk_status (chk_status),
        .chk_local  (chk_local),
        .chk_full   (chk_full),
        .is_write   (req_q.write),
        .loc_ack    (loc_ack),
        .rem_ack    (rem_ack),
        .rsp_ready  (rsp_ready),
        .state      (state),
        .req_ready  (req_ready),
        .loc_req    (loc_req),
        .loc_we     (loc_we),
        .rem_req    (rem_req),
        .rsp_valid  (rsp_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q    <= '0;
            status_q <= CFG_OK;
            word_q   <= '0;
        end else begin
            if (req_ready && req_valid) begin
                req_q.write   <= req_write;
                req_q.bus     <= req_bus;
                req_q.primary <= req_primary;
                req_q.dev     <= req_dev;
                req_q.func    <= req_func;
                req_q.regno   <= req_reg;
                req_q.size    <= req_size;
                req_q.wdata   <= req_wdata;
            end
            if (state == ST_CHECK)
                status_q <= chk_status;
            if ((state == ST_LOC_READ) && loc_ack)
                word_q <= loc_rdata;
            if ((state == ST_REMOTE) && rem_ack)
                word_q <= rem_rdata;
        end
    end

    always_comb begin
        case (status_q)
            CFG_NO_DEV:  rsp_rdata = '1;
            CFG_BAD_REG: rsp_rdata = '0;
            default:     rsp_rdata = req_q.write ? '0 : rd_field;
        endcase
    end

    assign rsp_status = status_q;
    assign loc_addr   = {req_q.regno[REG_W-1:OFF_W], {OFF_W{1'b0}}};
    assign loc_wdata  = chk_full ? req_q.wdata : merged;
    assign rem_we     = req_q.write;
    assign rem_addr   = ecam_addr;
    assign rem_be     = lane_be;
    assign rem_wdata  = lane_wdata;

    assert_no_access_on_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_req || rem_req) |-> (status_q == CFG_OK));
    assert_local_only_root_R5: assert property (@(posedge clk) disable iff (!rst_n)
        loc_req |-> (req_q.bus == root_bus));
    assert_remote_not_root_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rem_req |-> (req_q.bus != root_bus));
    assert_narrow_reads_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loc_we) && (req_q.size != SIZE_W'(BYTES)) |-> $past(loc_ack));
    assert_full_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loc_we) && (req_q.size == SIZE_W'(BYTES)) |-> !$past(loc_req));
    assert_remote_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rem_req && rem_we |-> ($countones(rem_be) == int'(req_q.size)));
    assert_no_dev_only_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (status_q == CFG_NO_DEV) |-> (req_q.dev != '0));
    assert_loc_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        loc_req && !loc_ack |=> $stable(loc_addr) && $stable(loc_wdata));
    assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> $stable(rsp_status) && $stable(rsp_rdata));
endmodule

// File: tb/test_cfg_access_router.sv
module test_cfg_access_router;
    localparam logic [7:0] ROOT = 8'h02;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [7:0]  req_bus = '0, req_primary = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0, req_size = '0;
    logic [11:0] req_reg = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_ready = 1'b0;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_rdata;
    logic        loc_req, loc_we, loc_ack = 1'b0;
    logic [11:0] loc_addr;
    logic [31:0] loc_wdata, loc_rdata = '0;
    logic        rem_req, rem_we, rem_ack = 1'b0;
    logic [27:0] rem_addr;
    logic [3:0]  rem_be;
    logic [31:0] rem_wdata, rem_rdata = '0;

    cfg_access_router i_cfg_access_router (
        .clk(clk), .rst_n(rst_n), .root_bus(ROOT),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bus(req_bus), .req_primary(req_primary), .req_dev(req_dev),
        .req_func(req_func), .req_reg(req_reg), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_ack(loc_ack), .loc_rdata(loc_rdata),
        .rem_req(rem_req), .rem_we(rem_we), .rem_addr(rem_addr), .rem_be(rem_be),
        .rem_wdata(rem_wdata), .rem_ack(rem_ack), .rem_rdata(rem_rdata)
    );

    int checks = 0, failures = 0;
    bit done = 0;
    int n_loc_rd = 0, n_loc_wr = 0, n_rem = 0;
    int loc_wait = 0, rem_wait = 0;
    logic [31:0] loc_mem [1024];
    logic [27:0] last_rem_addr = '0;
    logic [3:0]  last_rem_be = '0;
    logic [31:0] last_rem_wdata = '0;
    logic        last_rem_we = 1'b0;

    function automatic logic [31:0] rem_word(logic [27:0] a);
        return {a[27:2], 6'b0} ^ 32'h3C5A_F00D;
    endfunction

    function automatic logic [1:0] exp_status(logic [7:0] bus, logic [7:0] prim,
                                              logic [4:0] dev, logic [11:0] rg, logic [2:0] sz);
        if ((bus == ROOT || prim == ROOT) && dev != 0) return 2'd2;
        if (!(sz == 1 || sz == 2 || sz == 4)) return 2'd1;
        if ((int'(rg) % int'(sz)) != 0) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic [31:0] lane_mask(logic [11:0] rg, logic [2:0] sz);
        logic [63:0] m;
        m = ((64'd1 << (8 * int'(sz))) - 64'd1) << (8 * int'(rg[1:0]));
        return m[31:0];
    endfunction

    function automatic logic [31:0] extract(logic [31:0] w, logic [11:0] rg, logic [2:0] sz);
        logic [63:0] m;
        m = (64'd1 << (8 * int'(sz))) - 64'd1;
        return 32'(({32'b0, w} >> (8 * int'(rg[1:0]))) & m);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Local port responder: ack after a random delay, one cycle wide
    always @(negedge clk) begin
        if (loc_ack) loc_ack = 1'b0;
        else if (loc_req) begin
            if (loc_wait > 0) loc_wait--;
            else begin
                loc_ack = 1'b1;
                if (loc_we) begin
                    loc_mem[loc_addr[11:2]] = loc_wdata;
                    n_loc_wr++;
                end else begin
                    loc_rdata = loc_mem[loc_addr[11:2]];
                    n_loc_rd++;
                end
                loc_wait = int'($urandom % 3);
            end
        end
    end

    // Remote port responder
    always @(negedge clk) begin
        if (rem_ack) rem_ack = 1'b0;
        else if (rem_req) begin
            if (rem_wait > 0) rem_wait--;
            else begin
                rem_ack = 1'b1;
                n_rem++;
                last_rem_addr  = rem_addr;
                last_rem_be    = rem_be;
                last_rem_wdata = rem_wdata;
                last_rem_we    = rem_we;
                rem_rdata      = rem_word(rem_addr);
                rem_wait = int'($urandom % 3);
            end
        end
    end

    task automatic run(input logic wr, input logic [7:0] bus, input logic [7:0] prim,
                       input logic [4:0] dev, input logic [2:0] fn, input logic [11:0] rg,
                       input logic [2:0] sz, input logic [31:0] wd);
        logic [1:0]  est, st;
        logic [31:0] pre, dat, expw;
        int b_rd, b_wr, b_rem, hold;
        string etag;
        logic [7:0] be8;
        est   = exp_status(bus, prim, dev, rg, sz);
        etag  = (est == 2) ? "R4" : ((est == 1) ? ((sz == 1 || sz == 2 || sz == 4) ? "R2" : "R3") : "R10");
        b_rd  = n_loc_rd; b_wr = n_loc_wr; b_rem = n_rem;
        pre   = loc_mem[rg[11:2]];
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_write = wr; req_bus = bus; req_primary = prim; req_dev = dev;
        req_func = fn; req_reg = rg; req_size = sz; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R11 ready low while busy", 32'(req_ready), 32'd0);
        while (!rsp_valid) @(negedge clk);
        st = rsp_status; dat = rsp_rdata;
        hold = int'($urandom % 3);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check(rsp_valid && rsp_status == st && rsp_rdata == dat, "R11 response held",
                  rsp_rdata, dat);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;

        check(st == est, {etag, " status"}, 32'(st), 32'(est));
        if (est != 0) begin
            check(n_loc_rd == b_rd && n_loc_wr == b_wr && n_rem == b_rem,
                  {etag, " no access on error"}, 32'(n_loc_rd + n_loc_wr + n_rem),
                  32'(b_rd + b_wr + b_rem));
            if (!wr)
                check(dat == ((est == 2) ? 32'hFFFF_FFFF : 32'h0), {etag, " error read data"},
                      dat, (est == 2) ? 32'hFFFF_FFFF : 32'h0);
        end else if (bus == ROOT) begin
            if (!wr) begin
                check(n_loc_rd == b_rd + 1 && n_loc_wr == b_wr && n_rem == b_rem,
                      "R5 local read routing", 32'(n_loc_rd - b_rd), 32'd1);
                check(dat == extract(pre, rg, sz), "R9 local read data", dat, extract(pre, rg, sz));
            end else if (sz == 4) begin
                check(n_loc_rd == b_rd && n_loc_wr == b_wr + 1 && n_rem == b_rem,
                      "R7 single full write", 32'(n_loc_rd - b_rd), 32'd0);
                check(loc_mem[rg[11:2]] == wd, "R7 full word stored", loc_mem[rg[11:2]], wd);
            end else begin
                expw = (pre & ~lane_mask(rg, sz)) | ((wd << (8 * int'(rg[1:0]))) & lane_mask(rg, sz));
                check(n_loc_rd == b_rd + 1 && n_loc_wr == b_wr + 1 && n_rem == b_rem,
                      "R6 read then write", 32'(n_loc_wr - b_wr), 32'd1);
                check(loc_mem[rg[11:2]] == expw, "R6 merged word", loc_mem[rg[11:2]], expw);
            end
        end else begin
            check(n_rem == b_rem + 1 && n_loc_rd == b_rd && n_loc_wr == b_wr,
                  "R5 remote routing", 32'(n_rem - b_rem), 32'd1);
            check(last_rem_addr == {bus, dev, fn, rg}, "R1 window address",
                  32'(last_rem_addr), 32'({bus, dev, fn, rg}));
            if (wr) begin
                be8  = ((8'd1 << sz) - 8'd1) << rg[1:0];
                expw = (wd << (8 * int'(rg[1:0]))) & lane_mask(rg, sz);
                check(last_rem_we && last_rem_be == be8[3:0], "R8 byte enables",
                      32'(last_rem_be), 32'(be8[3:0]));
                check(last_rem_wdata == expw, "R8 lane data", last_rem_wdata, expw);
            end else begin
                check(dat == extract(rem_word({bus, dev, fn, rg}), rg, sz), "R9 remote read data",
                      dat, extract(rem_word({bus, dev, fn, rg}), rg, sz));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7215));
        for (int i = 0; i < 1024; i++) loc_mem[i] = (i * 32'h0101_0101) ^ 32'hC0DE_0000;
        repeat (3) begin
            @(negedge clk);
            check(req_ready && !rsp_valid && !loc_req && !rem_req, "R12 reset state",
                  {28'b0, req_ready, rsp_valid, loc_req, rem_req}, 32'h8);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid && !loc_req && !rem_req, "R12 after reset",
              {28'b0, req_ready, rsp_valid, loc_req, rem_req}, 32'h8);

        run(0, ROOT, 8'h00, 0, 0, 12'h013, 1, 32'h0);            // R9 byte at lane 3
        run(1, ROOT, 8'h00, 0, 0, 12'h0A6, 2, 32'hFFFF_BEEF);    // R6 upper bits ignored
        run(1, ROOT, 8'h00, 0, 0, 12'h0A4, 4, 32'h1234_5678);    // R7
        run(0, ROOT, 8'h00, 0, 0, 12'h0A4, 4, 32'h0);            // R9 full word
        run(1, ROOT, 8'h00, 0, 0, 12'h0A5, 1, 32'h0000_0077);    // R6 byte merge
        run(0, ROOT, 8'h00, 0, 0, 12'h102, 4, 32'h0);            // R2
        run(1, ROOT, 8'h00, 0, 0, 12'h101, 2, 32'h0000_5555);    // R2 write
        run(0, ROOT, 8'h00, 0, 0, 12'h100, 3, 32'h0);            // R3
        run(0, 8'h07, 8'h05, 0, 0, 12'h100, 0, 32'h0);           // R3 size 0
        run(1, 8'h07, 8'h05, 0, 0, 12'h100, 7, 32'h1);           // R3 size 7
        run(0, ROOT, 8'h00, 1, 0, 12'h000, 4, 32'h0);            // R4 root bus
        run(0, 8'h03, ROOT, 4, 0, 12'h001, 4, 32'h0);            // R4 priority over R2
        run(0, 8'h09, 8'h03, 5, 2, 12'h2FC, 4, 32'h0);           // R1 deep bus, dev 5 legal
        run(1, 8'h03, ROOT, 0, 1, 12'h0C5, 1, 32'h0000_00AB);    // R8 byte lane 1
        run(0, 8'h03, ROOT, 0, 7, 12'h0C6, 2, 32'h0);            // R9 remote half

        for (int n = 0; n < 400; n++) begin
            logic [7:0] b, p;
            logic [4:0] d;
            logic [2:0] s;
            int pick;
            pick = int'($urandom % 4);
            b = (pick == 0) ? ROOT : ((pick == 1) ? ROOT + 8'd1 : 8'($urandom));
            p = (pick == 1) ? ROOT : 8'($urandom);
            d = ($urandom % 3 == 0) ? 5'($urandom) : 5'd0;
            if ($urandom % 10 < 7) begin
                pick = int'($urandom % 3);
                s = (pick == 0) ? 3'd1 : ((pick == 1) ? 3'd2 : 3'd4);
            end else s = 3'($urandom);
            run(1'($urandom), b, p, d, 3'($urandom), 12'($urandom), s, $urandom);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule